// File: doc/BRIEF.md
# Power-Good Gated Thermal Trip Latch

This block compares a digital junction-temperature code with a programmable trip level and raises a sticky thermal-trip flag. Together with the flag it raises a request to stop the internal clocks. The block watches the temperature only after the power-good input has been steady high for a set number of clock cycles. When power-good falls, the flag is cleared and the comparison is switched off.

Power-good comes in asynchronously. It passes through a two-flop synchronizer before it reaches anything else. An arming counter starts at the synchronized rising edge. Any synchronized low clears the counter, the arm flag and the trip latch on the next edge. The trip level is held in an unsigned 8-bit register. Its reset value is 135 (one code step per degree Celsius). A load strobe replaces it.

Top module: `thermtrip_guard`

## Requirements
- R1: After a synchronous active-low reset, `therm_trip` and `clk_halt_req` are 0 and the trip level is 135. With that default, a code of 134 does not trip and a code of 135 does.
- R2: Power-good passes through two flops. Arming completes at the (2+ARM_CYCLES)-th rising clock edge after `pwr_good` rises. `therm_trip` can be 1 no earlier than one edge later.
- R3: While the block is armed, `therm_trip` is set at the next edge if `temp_code >= trip_level` (unsigned 8-bit compare). It stays 0 if `temp_code < trip_level`.
- R4: Once set, `therm_trip` stays 1 whatever `temp_code` does, as long as the synchronized power-good stays high.
- R5: When `pwr_good` falls, `therm_trip` is still 1 after the second clock edge and is 0 after the third.
- R6: Temperature codes at or above the trip level that occur before arming completes are not remembered. Only codes sampled while armed can set the trip.
- R7: A power-good drop during the arming window restarts the count. A full ARM_CYCLES window is needed after the next synchronized rise.
- R8: `clk_halt_req` equals `therm_trip` at every cycle.
- R9: When `lvl_load` is 1 at a clock edge, `lvl_value` becomes the trip level. It is used for comparisons from the next edge on.
- R10: After power-good drops and returns, a temperature still at or above the trip level sets the trip again at the same R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Asynchronous power-good indication |
| temp_code | input | 8 | Junction-temperature code, unsigned |
| lvl_load | input | 1 | Strobe that loads a new trip level |
| lvl_value | input | 8 | New trip level |
| therm_trip | output | 1 | Sticky thermal-trip flag |
| clk_halt_req | output | 1 | Request to stop the internal clocks |

## Verification
The assertions assume that `temp_code` and `lvl_value` are already synchronous to `clk`. Only `pwr_good` is allowed to change without regard to the clock. The assertions also assume that `lvl_load` changes the level only as a single-cycle event. The bench drives every input on the falling clock edge, so each value is stable through the next rising edge. It keeps the temperature fixed over each armed window, so each sampling point has one expected trip value. The bench uses a short arming parameter so that every edge-exact boundary in R2 and R5 is reached within a few cycles.

// File: rtl/thermtrip_pkg.sv
// Shared width and default constants for the thermal trip block.
package thermtrip_pkg;
    localparam int TEMP_W = 8;
    typedef logic [TEMP_W-1:0] temp_t;
    localparam temp_t LEVEL_RESET = temp_t'(135);
endpackage

// File: rtl/thermtrip_pg_sync.sv
// Two-flop synchronizer for the power-good input.
// Assumes: pg_async may change at any time; the output is pg_async delayed by two edges.
module thermtrip_pg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_async,
    output logic pg_sync
);
    logic meta_q;

    // Shift power-good through two flops; reset forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= 1'b0;
            pg_sync <= 1'b0;
        end else begin
            meta_q  <= pg_async;
            pg_sync <= meta_q;
        end
    end
endmodule

// File: rtl/thermtrip_arm_timer.sv
// Counts ARM_CYCLES edges of synchronized power-good high, then raises armed.
// Assumes: pg_sync is already synchronous; a low pg_sync clears all state.
module thermtrip_arm_timer #(
    parameter int ARM_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_sync,
    output logic armed
);
    localparam int CNT_W = $clog2(ARM_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ARM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up while power-good is high and the timer is not armed; set armed at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_sync) begin
            cnt_q <= '0;
            armed <= 1'b0;
        end else if (!armed) begin
            if (cnt_q == LAST) begin
                armed <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2, R7: arming only ever follows a cycle in which power-good was high.
    a_r2_arm_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(pg_sync));
    // R7: synchronized power-good low disarms on the next edge.
    a_r7_disarm_on_pg_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_sync |=> !armed);
endmodule

// File: rtl/thermtrip_latch.sv
// Holds the trip level register and the sticky trip flag.
// Assumes: temp_code and lvl_value are synchronous to clk.
module thermtrip_latch
    import thermtrip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pg_sync,
    input  logic  armed,
    input  temp_t temp_code,
    input  logic  lvl_load,
    input  temp_t lvl_value,
    output logic  trip
);
    temp_t level_q;
    logic  over;

    // Trip level register, reset to the nominal trip code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LEVEL_RESET;
        end else if (lvl_load) begin
            level_q <= lvl_value;
        end
    end

    // Unsigned at-or-above comparison.
    always_comb over = (temp_code >= level_q);

    // Sticky flag: cleared by a low power-good, set while armed and over the level.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_sync) begin
            trip <= 1'b0;
        end else if (armed && over) begin
            trip <= 1'b1;
        end
    end

    // R4: the trip holds while power-good stays high.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && pg_sync) |=> trip);
    // R5: a low power-good clears the trip.
    a_r5_clear_on_pg_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_sync |=> !trip);
    // R6: the trip rises only out of an armed cycle.
    a_r6_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(armed));
    // R3: armed, power-good high and at or above the level sets the trip.
    a_r3_set_when_over: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pg_sync && temp_code >= level_q) |=> trip);
endmodule

// File: rtl/thermtrip_guard.sv
// Top: power-good gated thermal trip latch with a clock-halt request.
// Assumes: pwr_good is asynchronous; the other inputs are synchronous to clk.
module thermtrip_guard #(
    parameter int ARM_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [7:0] temp_code,
    input  logic       lvl_load,
    input  logic [7:0] lvl_value,
    output logic       therm_trip,
    output logic       clk_halt_req
);
    logic pg_s;
    logic armed;
    logic trip;

    thermtrip_pg_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pg_async(pwr_good), .pg_sync(pg_s)
    );

    thermtrip_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
        .clk(clk), .rst_n(rst_n), .pg_sync(pg_s), .armed(armed)
    );

    thermtrip_latch u_latch (
        .clk(clk), .rst_n(rst_n), .pg_sync(pg_s), .armed(armed),
        .temp_code(temp_code), .lvl_load(lvl_load), .lvl_value(lvl_value),
        .trip(trip)
    );

    // Drive both outputs from the single trip flag.
    always_comb begin
        therm_trip   = trip;
        clk_halt_req = trip;
    end

    // R8: the halt request tracks the trip flag.
    a_r8_halt_follows_trip: assert property (@(posedge clk) disable iff (!rst_n)
        clk_halt_req == therm_trip);
endmodule

// File: tb/sim_thermtrip_guard.sv
module sim_thermtrip_guard;
    localparam int ARM = 6;
    localparam int NV  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic [7:0] temp_code = 8'd0;
    logic lvl_load = 1'b0;
    logic [7:0] lvl_value = 8'd0;
    logic therm_trip, clk_halt_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermtrip_guard #(.ARM_CYCLES(ARM)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .temp_code(temp_code),
        .lvl_load(lvl_load), .lvl_value(lvl_value),
        .therm_trip(therm_trip), .clk_halt_req(clk_halt_req)
    );

    // Each vector: {trip level, temperature, expected trip}.
    typedef struct packed { logic [7:0] lvl; logic [7:0] temp; logic exp; } vec_t;
    localparam vec_t VT [NV] = '{
        '{8'd100, 8'd99,  1'b0},
        '{8'd100, 8'd100, 1'b1},
        '{8'd100, 8'd101, 1'b1},
        '{8'd255, 8'd254, 1'b0},
        '{8'd0,   8'd0,   1'b1},
        '{8'd200, 8'd255, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic load_level(input logic [7:0] v);
        lvl_load = 1'b1; lvl_value = v;
        step(1);
        lvl_load = 1'b0;
    endtask

    // Drop power-good long enough to clear everything.
    task automatic pg_off;
        pwr_good = 1'b0;
        step(4);
    endtask

    initial begin
        step(3);
        chk("R1 trip after reset", therm_trip, 1'b0);
        chk("R1 halt after reset", clk_halt_req, 1'b0);
        rst_n = 1'b1;
        step(1);

        // Vector table walk: R2 timing, R3 compare, R4 sticky, R5 clear, R8 mirror, R9 load.
        foreach (VT[i]) begin
            pg_off();
            load_level(VT[i].lvl);
            temp_code = VT[i].temp;
            pwr_good = 1'b1;
            step(2 + ARM);
            chk("R2 not before arm", therm_trip, 1'b0);
            step(1);
            chk("R3 compare", therm_trip, VT[i].exp);
            chk("R8 halt mirrors", clk_halt_req, VT[i].exp);
            temp_code = 8'd0;
            step(3);
            chk("R4 sticky", therm_trip, VT[i].exp);
            pwr_good = 1'b0;
            step(2);
            chk("R5 held two edges", therm_trip, VT[i].exp);
            step(1);
            chk("R5 cleared third edge", therm_trip, 1'b0);
        end

        // R1: default level 135 after reset.
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        temp_code = 8'd134; pwr_good = 1'b1;
        step(2 + ARM + 2);
        chk("R1 default level 134 no trip", therm_trip, 1'b0);
        temp_code = 8'd135;
        step(1);
        chk("R1 default level 135 trips", therm_trip, 1'b1);

        // R10: retrip after power-good returns, same timing.
        pwr_good = 1'b0; step(3);
        chk("R10 cleared", therm_trip, 1'b0);
        pwr_good = 1'b1;
        step(2 + ARM);
        chk("R10 not before arm", therm_trip, 1'b0);
        step(1);
        chk("R10 retrip", therm_trip, 1'b1);

        // R6: hot only during the arming window is forgotten.
        pg_off();
        temp_code = 8'd200; pwr_good = 1'b1;
        step(2 + ARM - 1);
        temp_code = 8'd10;
        step(5);
        chk("R6 pre-arm hot forgotten", therm_trip, 1'b0);

        // R7: a drop mid-window restarts the count.
        pg_off();
        temp_code = 8'd200; pwr_good = 1'b1;
        step(2 + ARM / 2);
        pwr_good = 1'b0; step(1);
        pwr_good = 1'b1;
        step(2 + ARM);
        chk("R7 restart no early trip", therm_trip, 1'b0);
        step(1);
        chk("R7 trip after full window", therm_trip, 1'b1);

        // R9: the new level applies from the next edge.
        temp_code = 8'd0;
        pg_off();
        load_level(8'd50);
        temp_code = 8'd40; pwr_good = 1'b1;
        step(2 + ARM + 2);
        chk("R9 below new level", therm_trip, 1'b0);
        load_level(8'd40);
        step(1);
        chk("R9 new level used", therm_trip, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule